// File: doc/BRIEF.md
# Zero-Wait Burst Synchronous SRAM

This block is a synthesizable single-clock synchronous SRAM. Address, control and write data are registered on the rising edge of the clock. Any cycle can be a read, a write or a deselect, and the bus never needs an idle cycle when it changes direction. A write takes its data one enabled edge after its address. The data waits in a one-entry pending buffer and reaches the array at the next enabled edge. A read of an address that is still pending gets the buffered bytes through a per-lane bypass.

A load cycle takes an external address. Advance cycles then step a 2-bit burst counter that changes only the two lowest address bits. A mode input chooses between linear and interleaved order. The data word is split into byte lanes of nine bits: eight data bits and one parity bit. Each lane has its own write mask. A clock-enable input freezes the whole block. A snooze input blanks the output and drops writes.

Top module: `zw_burst_sram`

## Requirements
- R1: While reset is asserted and after its release, the block is deselected, `rdata_oe_o` is low and `rdata_o` is zero.
- R2: When `clk_en_ni` is high at an edge, every input is ignored for that edge. The cycle type, burst position, pending write and memory contents all keep their values.
- R3: An enabled edge with `adv_i` low loads `addr_i` and clears the burst position. The block is selected only when `sel_a_ni` is low, `sel_b_i` is high and `sel_c_ni` is low; the cycle is then a read when `wr_ni` is high and a write when it is low. An unselected load starts a deselect cycle.
- R4: With `ilv_mode_i` low, the two low address bits of a burst are (start + count) mod 4, where count is the number of advance edges since the load. The upper address bits stay equal to the loaded address.
- R5: With `ilv_mode_i` high, the two low address bits are start XOR count.
- R6: The data of a write cycle is sampled on `wdata_i` at the next enabled edge. Lane k covers bits [9k+8:9k], and bit 9k+8 is its parity bit. Only lanes whose `lane_wr_ni` bit was low at the address edge are stored. The other lanes keep their old contents.
- R7: Read data is flow-through. After the edge that registers a read address, `rdata_o` shows that word in the same cycle. The word includes every lane of a write whose data was sampled at that same edge or earlier.
- R8: Reads and writes may alternate on consecutive cycles with no idle cycle, and every read returns the latest written data.
- R9: `rdata_oe_o` is high only in a read cycle while `out_en_ni` is low and `snooze_i` is low. Whenever it is low, `rdata_o` is zero.
- R10: A write whose data edge sees `snooze_i` high is discarded and leaves the memory unchanged.
- R11: An advance edge keeps the current cycle type and ignores `wr_ni`, the selects and `addr_i`. An advance during a deselect cycle stays deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_en_ni | input | 1 | Clock enable, active low; high freezes the block |
| adv_i | input | 1 | High: advance the burst; low: load a new address |
| wr_ni | input | 1 | Low at a load edge: write cycle |
| lane_wr_ni | input | LANES | Per-lane write mask, active low |
| sel_a_ni | input | 1 | Chip select, active low |
| sel_b_i | input | 1 | Chip select, active high |
| sel_c_ni | input | 1 | Chip select, active low |
| out_en_ni | input | 1 | Output enable, active low |
| ilv_mode_i | input | 1 | Burst order: 1 interleaved, 0 linear |
| snooze_i | input | 1 | Blanks the output and drops writes |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 9*LANES | Write data, one enabled edge after its address |
| rdata_o | output | 9*LANES | Read data, zero when not driven |
| rdata_oe_o | output | 1 | Read data valid and driven |

## Verification
The first stimulus is a full linear burst fill, followed by read bursts from every start offset in both orders. A counter that steps in the wrong order, or that carries into the upper bits, shows up here. Partially masked writes that are read back on the very next cycle separate a correct bypass from a stale array read and from a bypass that ignores the lane mask. Alternating read and write loads probe the turnaround. Clock-enable holds placed inside read and write bursts expose any state that moves while frozen. Snooze, output-enable and deselect cycles show whether output gating and dropped writes are told apart. A long constrained-random phase then mixes all of these, with mode changes in the middle of bursts.

// File: rtl/zw_sram_pkg.sv
package zw_sram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;

  // low address bits of a burst beat
  function automatic logic [1:0] burst_low(input logic [1:0] start,
                                           input logic [1:0] cnt,
                                           input logic       ilv);
    return ilv ? (start ^ cnt) : (start + cnt);
  endfunction
endpackage

// File: rtl/zw_burst_ctrl.sv
module zw_burst_ctrl
  import zw_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              adv_i,
  input  logic              wr_ni,
  input  logic              sel_i,
  input  logic              ilv_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]  lane_wr_ni,
  output op_e               op_o,
  output logic [1:0]        cnt_o,
  output logic [ADDR_W-1:0] eff_addr_o,
  output logic [LANES-1:0]  lane_we_o
);
  op_e               op_q;
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q;
  logic [LANES-1:0]  lane_we_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q      <= OP_IDLE;
      base_q    <= '0;
      cnt_q     <= '0;
      lane_we_q <= '0;
    end else if (en_i) begin
      lane_we_q <= ~lane_wr_ni;
      if (!adv_i) begin
        base_q <= addr_i;
        cnt_q  <= '0;
        op_q   <= !sel_i ? OP_IDLE : (wr_ni ? OP_RD : OP_WR);
      end else if (op_q != OP_IDLE) begin
        cnt_q <= cnt_q + 2'd1;
      end
    end
  end

  assign op_o       = op_q;
  assign cnt_o      = cnt_q;
  assign lane_we_o  = lane_we_q;
  assign eff_addr_o = {base_q[ADDR_W-1:2], burst_low(base_q[1:0], cnt_q, ilv_i)};
endmodule

// File: rtl/zw_late_write.sv
module zw_late_write
  import zw_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int DATA_W = 36
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              snooze_i,
  input  op_e               op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]  lane_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              pend_v_o,
  output logic [ADDR_W-1:0] pend_addr_o,
  output logic [LANES-1:0]  pend_we_o,
  output logic [DATA_W-1:0] pend_data_o
);
  logic take;
  assign take = (op_i == OP_WR) && !snooze_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_v_o    <= 1'b0;
      pend_addr_o <= '0;
      pend_we_o   <= '0;
      pend_data_o <= '0;
    end else if (en_i) begin
      pend_v_o <= take;
      if (take) begin
        pend_addr_o <= addr_i;
        pend_we_o   <= lane_we_i;
        pend_data_o <= wdata_i;
      end
    end
  end
endmodule

// File: rtl/zw_mem_array.sv
module zw_mem_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk_i,
  input  logic                    we_i,
  input  logic [ADDR_W-1:0]       waddr_i,
  input  logic [LANES-1:0]        lane_we_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0]       raddr_i,
  output logic [LANES*LANE_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem_q [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i && lane_we_i[l]) mem_q[waddr_i] <= wdata_i[l*LANE_W +: LANE_W];
    end
    assign rdata_o[l*LANE_W +: LANE_W] = mem_q[raddr_i];
  end
endmodule

// File: rtl/zw_burst_sram.sv
module zw_burst_sram
  import zw_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clk_en_ni,
  input  logic                  adv_i,
  input  logic                  wr_ni,
  input  logic [LANES-1:0]      lane_wr_ni,
  input  logic                  sel_a_ni,
  input  logic                  sel_b_i,
  input  logic                  sel_c_ni,
  input  logic                  out_en_ni,
  input  logic                  ilv_mode_i,
  input  logic                  snooze_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [9*LANES-1:0]    wdata_i,
  output logic [9*LANES-1:0]    rdata_o,
  output logic                  rdata_oe_o
);
  localparam int LANE_W = 9;
  localparam int DATA_W = LANES * LANE_W;

  logic              en;
  logic              sel_ok;
  op_e               op_q;
  logic [1:0]        cnt_q;
  logic [ADDR_W-1:0] eff_addr;
  logic [LANES-1:0]  lane_we;
  logic              pend_v;
  logic [ADDR_W-1:0] pend_addr;
  logic [LANES-1:0]  pend_we;
  logic [DATA_W-1:0] pend_data;
  logic [DATA_W-1:0] arr_rdata;
  logic [DATA_W-1:0] fwd_rdata;
  logic              hit;

  assign en     = !clk_en_ni;
  assign sel_ok = !sel_a_ni && sel_b_i && !sel_c_ni;

  zw_burst_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en),
    .adv_i      (adv_i),
    .wr_ni      (wr_ni),
    .sel_i      (sel_ok),
    .ilv_i      (ilv_mode_i),
    .addr_i     (addr_i),
    .lane_wr_ni (lane_wr_ni),
    .op_o       (op_q),
    .cnt_o      (cnt_q),
    .eff_addr_o (eff_addr),
    .lane_we_o  (lane_we)
  );

  zw_late_write #(.ADDR_W(ADDR_W), .LANES(LANES), .DATA_W(DATA_W)) u_lwr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en),
    .snooze_i    (snooze_i),
    .op_i        (op_q),
    .addr_i      (eff_addr),
    .lane_we_i   (lane_we),
    .wdata_i     (wdata_i),
    .pend_v_o    (pend_v),
    .pend_addr_o (pend_addr),
    .pend_we_o   (pend_we),
    .pend_data_o (pend_data)
  );

  // pending word retires at the next enabled edge
  zw_mem_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk_i     (clk_i),
    .we_i      (en && pend_v),
    .waddr_i   (pend_addr),
    .lane_we_i (pend_we),
    .wdata_i   (pend_data),
    .raddr_i   (eff_addr),
    .rdata_o   (arr_rdata)
  );

  assign hit = pend_v && (pend_addr == eff_addr);

  for (genvar l = 0; l < LANES; l++) begin : g_fwd
    assign fwd_rdata[l*LANE_W +: LANE_W] = (hit && pend_we[l]) ?
        pend_data[l*LANE_W +: LANE_W] : arr_rdata[l*LANE_W +: LANE_W];
  end

  assign rdata_oe_o = (op_q == OP_RD) && !out_en_ni && !snooze_i;
  assign rdata_o    = rdata_oe_o ? fwd_rdata : '0;
endmodule

// File: rtl/zw_burst_sram_chk.sv
module zw_burst_sram_chk
  import zw_sram_pkg::*;
#(
  parameter int DATA_W = 36
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clk_en_ni,
  input logic              adv_i,
  input logic              sel_ok,
  input logic              out_en_ni,
  input logic              snooze_i,
  input op_e               op_q,
  input logic [1:0]        cnt_q,
  input logic              pend_v,
  input logic [DATA_W-1:0] rdata_o,
  input logic              rdata_oe_o
);
  // R2
  freeze_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_ni |=> ($stable(op_q) && $stable(cnt_q) && $stable(pend_v)));

  // R3
  desel_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_en_ni && !adv_i && !sel_ok) |=> (op_q == OP_IDLE));

  // R3
  load_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_en_ni && !adv_i) |=> (cnt_q == 2'd0));

  // R4
  burst_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_en_ni && adv_i && op_q != OP_IDLE) |=> (cnt_q == 2'($past(cnt_q) + 2'd1)));

  // R11
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_en_ni && adv_i && op_q == OP_IDLE) |=> (op_q == OP_IDLE));

  // R11
  type_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_en_ni && adv_i) |=> (op_q == $past(op_q)));

  // R9
  drive_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_oe_o |-> (!out_en_ni && !snooze_i && op_q == OP_RD));

  // R9
  quiet_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdata_oe_o |-> (rdata_o == '0));

  // R10
  snooze_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_en_ni && snooze_i) |=> !pend_v);
endmodule

bind zw_burst_sram zw_burst_sram_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .clk_en_ni  (clk_en_ni),
  .adv_i      (adv_i),
  .sel_ok     (sel_ok),
  .out_en_ni  (out_en_ni),
  .snooze_i   (snooze_i),
  .op_q       (op_q),
  .cnt_q      (cnt_q),
  .pend_v     (pend_v),
  .rdata_o    (rdata_o),
  .rdata_oe_o (rdata_oe_o)
);

// File: tb/zw_burst_sram_tb.sv
module zw_burst_sram_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW    = 6;
  localparam int LN    = 4;
  localparam int DW    = 9 * LN;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cke_n = 1'b0;
  logic          adv = 1'b0;
  logic          wr_n = 1'b1;
  logic [LN-1:0] bw_n = '1;
  logic          sa_n = 1'b1;
  logic          sb = 1'b0;
  logic          sc_n = 1'b1;
  logic          oe_n = 1'b0;
  logic          mode = 1'b0;
  logic          snz = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          rdata_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  zw_burst_sram #(.ADDR_W(AW), .LANES(LN)) u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .clk_en_ni  (cke_n),
    .adv_i      (adv),
    .wr_ni      (wr_n),
    .lane_wr_ni (bw_n),
    .sel_a_ni   (sa_n),
    .sel_b_i    (sb),
    .sel_c_ni   (sc_n),
    .out_en_ni  (oe_n),
    .ilv_mode_i (mode),
    .snooze_i   (snz),
    .addr_i     (addr),
    .wdata_i    (wdata),
    .rdata_o    (rdata),
    .rdata_oe_o (rdata_oe)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // reference model: 0 idle, 1 read, 2 write
  logic [DW-1:0] ref_mem [DEPTH];
  int            m_op = 0;
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_cnt = '0;
  logic [LN-1:0] m_bw = '0;

  function automatic logic [AW-1:0] m_eff();
    logic [1:0] lo;
    lo = mode ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
    return {m_base[AW-1:2], lo};
  endfunction

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old_w, logic [DW-1:0] new_w,
                                          logic [LN-1:0] we);
    logic [DW-1:0] r;
    r = old_w;
    for (int l = 0; l < LN; l++) if (we[l]) r[l*9 +: 9] = new_w[l*9 +: 9];
    return r;
  endfunction

  function automatic logic [DW-1:0] rnd_word();
    return DW'({$urandom, $urandom});
  endfunction

  task automatic check(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic tick(string req);
    logic [AW-1:0] ea;
    logic          exp_oe;
    @(posedge clk);
    if (!cke_n && rst_n) begin
      ea = m_eff();
      if (m_op == 2 && !snz) ref_mem[ea] = merge(ref_mem[ea], wdata, m_bw);
      m_bw = ~bw_n;
      if (!adv) begin
        m_base = addr;
        m_cnt  = 2'd0;
        m_op   = (!sa_n && sb && !sc_n) ? (wr_n ? 1 : 2) : 0;
      end else if (m_op != 0) begin
        m_cnt = m_cnt + 2'd1;
      end
    end
    @(negedge clk);
    exp_oe = (m_op == 1) && !oe_n && !snz;
    check(req, "oe", DW'(rdata_oe), DW'(exp_oe));
    check(req, "data", rdata, exp_oe ? ref_mem[m_eff()] : '0);
  endtask

  task automatic sel_on();
    sa_n = 1'b0; sb = 1'b1; sc_n = 1'b0;
  endtask

  task automatic load(string req, logic [AW-1:0] a, bit wr, logic [LN-1:0] m_n);
    cke_n = 1'b0; adv = 1'b0; sel_on(); wr_n = !wr; addr = a; bw_n = m_n;
    wdata = rnd_word();
    tick(req);
  endtask

  task automatic beat(string req, logic [LN-1:0] m_n);
    cke_n = 1'b0; adv = 1'b1; bw_n = m_n; wdata = rnd_word();
    tick(req);
  endtask

  task automatic desel(string req);
    cke_n = 1'b0; adv = 1'b0; sa_n = 1'b1; sb = 1'b1; sc_n = 1'b0;
    wdata = rnd_word();
    tick(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h2bd7));
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;

    // R1: outputs quiet under reset and just after release
    repeat (3) @(negedge clk);
    check("R1", "oe", DW'(rdata_oe), '0);
    check("R1", "data", rdata, '0);
    rst_n = 1'b1;
    oe_n = 1'b0;
    sel_on();
    adv = 1'b1;
    tick("R1");

    // R6: fill with linear write bursts, every lane
    mode = 1'b0;
    for (int b = 0; b < DEPTH / 4; b++) begin
      load("R6", AW'(b * 4), 1'b1, '0);
      for (int k = 0; k < 3; k++) beat("R6", '0);
    end
    desel("R6");

    // R4: linear read bursts from every start offset
    for (int s = 0; s < 4; s++) begin
      load("R4", AW'(20 + s), 1'b0, '1);
      for (int k = 0; k < 3; k++) beat("R4", '1);
    end
    // R5: interleaved read bursts
    mode = 1'b1;
    for (int s = 0; s < 4; s++) begin
      load("R5", AW'(36 + s), 1'b0, '1);
      for (int k = 0; k < 4; k++) beat("R5", '1);
    end
    // R5: interleaved write burst then linear readback
    load("R5", AW'(45), 1'b1, '0);
    for (int k = 0; k < 3; k++) beat("R5", '0);
    mode = 1'b0;
    load("R5", AW'(44), 1'b0, '1);
    for (int k = 0; k < 3; k++) beat("R5", '1);

    // R7: masked write read on the next cycle (bypass)
    load("R7", AW'(10), 1'b1, 4'b1010);
    load("R7", AW'(10), 1'b0, '1);
    load("R7", AW'(11), 1'b1, 4'b0110);
    load("R7", AW'(11), 1'b0, '1);
    load("R6", AW'(12), 1'b1, 4'b1111);
    load("R6", AW'(12), 1'b0, '1);

    // R8: alternate read and write each cycle
    for (int i = 0; i < 12; i++) load("R8", AW'(i % 3), (i % 2) == 0, 4'(i));
    load("R8", AW'(1), 1'b0, '1);

    // R2: freeze inside a read burst and inside a write burst
    load("R2", AW'(30), 1'b0, '1);
    beat("R2", '1);
    cke_n = 1'b1; adv = 1'b0; wr_n = 1'b0; addr = AW'(5); wdata = rnd_word(); tick("R2");
    cke_n = 1'b1; adv = 1'b1; tick("R2");
    beat("R2", '1);
    load("R2", AW'(50), 1'b1, '0);
    cke_n = 1'b1; adv = 1'b0; sa_n = 1'b1; wdata = rnd_word(); tick("R2");
    beat("R2", '0);
    load("R2", AW'(50), 1'b0, '1);
    beat("R2", '1);

    // R3/R11: deselect load, advance while deselected, wr_ni toggled in a burst
    desel("R3");
    beat("R11", '0);
    load("R3", AW'(7), 1'b0, '1);
    sa_n = 1'b0; sb = 1'b0; adv = 1'b0; wdata = rnd_word(); tick("R3");
    load("R11", AW'(16), 1'b0, '1);
    wr_n = 1'b0; addr = AW'(3); sa_n = 1'b1; beat("R11", '0);
    beat("R11", '0);
    sel_on();

    // R10: write data edge under snooze is dropped
    load("R10", AW'(60), 1'b1, '0);
    snz = 1'b1;
    load("R10", AW'(60), 1'b0, '1);
    snz = 1'b0;
    load("R10", AW'(60), 1'b0, '1);

    // R9: output enable gating
    oe_n = 1'b1;
    load("R9", AW'(8), 1'b0, '1);
    oe_n = 1'b0;
    beat("R9", '1);

    // R8: constrained random mix
    for (int i = 0; i < 4000; i++) begin
      cke_n = ($urandom_range(0, 9) == 0);
      adv   = ($urandom_range(0, 9) < 5);
      wr_n  = $urandom_range(0, 1) == 1;
      bw_n  = LN'($urandom);
      sa_n  = ($urandom_range(0, 9) == 0);
      sb    = ($urandom_range(0, 9) != 0);
      sc_n  = ($urandom_range(0, 9) == 0);
      oe_n  = ($urandom_range(0, 7) == 0);
      snz   = ($urandom_range(0, 19) == 0);
      if ($urandom_range(0, 15) == 0) mode = ~mode;
      addr  = AW'($urandom);
      wdata = rnd_word();
      tick("R8");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule